// File: doc/BRIEF.md
# Gap-Aware Adaptive Link Selector

This block picks one of several equal-cost parallel output links for every packet that passes through a switch stage. Each packet arrives as a one-cycle strobe that carries a flow hash, the current per-link congestion flags and a free-running timestamp. The block returns the chosen link index a fixed two cycles later. A small flow memory, addressed by the low bits of the hash, records for each flow whether it has been seen, which link it last used and when it last sent.

A configuration input selects one of three policies. Static hashing always maps a flow to the same link, so colliding flows can crowd onto one link. Adaptive mode keeps a flow on its recorded link and moves it to the lowest-numbered uncongested link only when two things hold: the flow has been idle for longer than a programmable gap, and its present link is congested. Because the idle gap is longer than any path skew, later packets cannot overtake earlier ones. Spraying mode ignores ordering and deals the packets of every flow round-robin over the links that are not congested.

All parallel links reach every destination, so any link is a legal replacement. The timestamp is a wrapping counter, and idle gaps are measured modulo its width.

Top module: `path_sel_top`

## Requirements
- R1: While reset is high and after it is released, `sel_valid` is 0, every flow entry is treated as never seen, and the spraying pointer starts at link 0.
- R2: Each cycle with `pkt_valid` high produces exactly one result: `sel_valid` is high two clock edges later with `sel_link` for that packet. Cycles without a strobe give `sel_valid` low at the same distance.
- R3: With `cfg_mode` 0 (static), or the unused code 3, the link is the hashed link, whatever the congestion. The hashed link is the XOR of bits 2k and 2k+1 of the hash into link bits 0 and 1 (for 4 links), that is, bit i of the hash folds into link bit i mod LINK_W, taken modulo the link count.
- R4: With `cfg_mode` 1 (adaptive), a flow whose entry (hash bits 5:0) has never been written since reset uses the hashed link, even when that link is congested.
- R5: In adaptive mode, a known flow whose gap (now minus last-seen time) is at most `cfg_gap` stays on its recorded link, even when that link is congested.
- R6: In adaptive mode, a known flow with a gap above `cfg_gap` whose recorded link is congested moves to the lowest-numbered uncongested link.
- R7: In adaptive mode, when every link is congested, a known flow stays on its recorded link.
- R8: In adaptive mode, a known flow whose recorded link is not congested stays on that link, whatever the gap.
- R9: The gap is computed modulo 2^TS_W, so a timestamp that has wrapped past zero gives the correct small positive gap.
- R10: With `cfg_mode` 2 (spray), the link is the first uncongested link at or after the round-robin pointer. The pointer then moves to the link after the chosen one, wrapping to 0.
- R11: In spray mode, when every link is congested, the hashed link is used and the pointer does not move.
- R12: Every accepted packet, in every mode, records its chosen link and its timestamp in its flow entry. A packet of the same flow in the very next cycle sees that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 static, 1 adaptive, 2 spray, 3 as static |
| cfg_gap | input | TS_W | Idle gap that must be exceeded before a flow may move |
| pkt_valid | input | 1 | One packet to route this cycle |
| pkt_hash | input | HASH_W | Flow hash of the packet |
| link_cong | input | N_LINKS | Congestion flag per link, 1 = congested |
| now_ts | input | TS_W | Free-running timestamp |
| sel_valid | output | 1 | Result valid |
| sel_link | output | LINK_W | Chosen link index |

## Verification
Every result appears at the second rising edge after its strobe: one edge captures the inputs together with the flow entry, and the next registers the choice. Congestion, mode and gap are taken at the first of those edges. The bench drives and samples on falling edges. It carries each expected value through a two-deep queue, so the value compared on a falling edge belongs to the strobe driven two falling edges earlier. Back-to-back packets of the same flow are included, which tests that each decision sees the entry written by the packet one cycle before it.

// File: rtl/psel_pkg.sv
package psel_pkg;
  localparam logic [1:0] MODE_STATIC = 2'd0;
  localparam logic [1:0] MODE_ADAPT  = 2'd1;
  localparam logic [1:0] MODE_SPRAY  = 2'd2;
endpackage

// File: rtl/psel_flow_table.sv
module psel_flow_table #(
  parameter int DEPTH  = 64,
  parameter int LINK_W = 2,
  parameter int TS_W   = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic              rd_vld,
  output logic [LINK_W-1:0] rd_link,
  output logic [TS_W-1:0]   rd_ts,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [LINK_W-1:0] wr_link,
  input  logic [TS_W-1:0]   wr_ts
);
  localparam int ENT_W = LINK_W + TS_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] mem_q;
  logic [ENT_W-1:0] byp_q;
  logic [DEPTH-1:0] seen;
  logic             vld_q;
  logic             byp_sel;
  logic             same_addr;

  assign same_addr = wr_en && (wr_addr == rd_addr);

  // payload: plain synchronous RAM, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_link, wr_ts};
    if (rd_en) begin
      mem_q <= mem[rd_addr];
      byp_q <= {wr_link, wr_ts};
    end
  end

  // seen bits live in registers so that reset clears every entry at once
  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= '0;
      vld_q   <= 1'b0;
      byp_sel <= 1'b0;
    end else begin
      if (wr_en) seen[wr_addr] <= 1'b1;
      if (rd_en) begin
        vld_q   <= seen[rd_addr] | same_addr;
        byp_sel <= same_addr;
      end
    end
  end

  assign rd_vld  = vld_q;
  assign rd_link = byp_sel ? byp_q[ENT_W-1:TS_W] : mem_q[ENT_W-1:TS_W];
  assign rd_ts   = byp_sel ? byp_q[TS_W-1:0]     : mem_q[TS_W-1:0];

  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && same_addr) |=> (rd_vld && rd_link == $past(wr_link) && rd_ts == $past(wr_ts))); // R12

  AST_RESET_UNSEEN: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_en && !wr_en) |=> !rd_vld); // R1
endmodule

// File: rtl/psel_link_pick.sv
module psel_link_pick #(
  parameter int N_LINKS = 4,
  localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic [N_LINKS-1:0] cong,
  input  logic [LINK_W-1:0]  start,
  output logic               any_free,
  output logic [LINK_W-1:0]  low_idx,
  output logic [LINK_W-1:0]  rot_idx
);
  assign any_free = ~&cong;

  // lowest-numbered free link: descending scan, the last hit wins
  always_comb begin
    low_idx = '0;
    for (int k = N_LINKS - 1; k >= 0; k--) begin
      if (!cong[k]) low_idx = LINK_W'(k);
    end
  end

  // first free link at or after start, rotating
  always_comb begin
    rot_idx = '0;
    for (int k = N_LINKS - 1; k >= 0; k--) begin : scan
      int j;
      j = (int'(start) + k) % N_LINKS;
      if (!cong[j]) rot_idx = LINK_W'(j);
    end
  end
endmodule

// File: rtl/psel_decide.sv
module psel_decide
  import psel_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int TS_W    = 16,
  localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_valid,
  input  logic [1:0]         s_mode,
  input  logic [TS_W-1:0]    s_gap,
  input  logic [TS_W-1:0]    s_ts,
  input  logic [N_LINKS-1:0] s_cong,
  input  logic [LINK_W-1:0]  s_hlink,
  input  logic               ent_vld,
  input  logic [LINK_W-1:0]  ent_link,
  input  logic [TS_W-1:0]    ent_ts,
  output logic               wr_en,
  output logic [LINK_W-1:0]  wr_link,
  output logic [TS_W-1:0]    wr_ts,
  output logic               sel_valid,
  output logic [LINK_W-1:0]  sel_link
);
  localparam logic [N_LINKS-1:0] ONE_HOT0 = N_LINKS'(1);
  localparam logic [LINK_W-1:0]  LAST    = LINK_W'(N_LINKS - 1);

  logic [LINK_W-1:0] rr_ptr, rr_nxt, pick;
  logic [LINK_W-1:0] low_idx, rot_idx;
  logic              any_free, migrate, is_adapt, is_spray;
  logic [TS_W-1:0]   idle_gap;

  psel_link_pick #(.N_LINKS(N_LINKS)) u_pick (
    .cong     (s_cong),
    .start    (rr_ptr),
    .any_free (any_free),
    .low_idx  (low_idx),
    .rot_idx  (rot_idx)
  );

  assign is_adapt = (s_mode == MODE_ADAPT);
  assign is_spray = (s_mode == MODE_SPRAY);
  assign idle_gap = s_ts - ent_ts;   // modular: wrap-safe
  assign migrate  = ent_vld && (idle_gap > s_gap) && s_cong[ent_link] && any_free;

  always_comb begin
    pick   = s_hlink;
    rr_nxt = rr_ptr;
    if (is_adapt) begin
      if (ent_vld) pick = migrate ? low_idx : ent_link;
    end else if (is_spray) begin
      if (any_free) begin
        pick = rot_idx;
        if (s_valid) rr_nxt = (rot_idx == LAST) ? '0 : rot_idx + 1'b1;
      end
    end
  end

  assign wr_en   = s_valid;
  assign wr_link = pick;
  assign wr_ts   = s_ts;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_link  <= '0;
      rr_ptr    <= '0;
    end else begin
      sel_valid <= s_valid;
      if (s_valid) sel_link <= pick;
      rr_ptr <= rr_nxt;
    end
  end

  AST_STATIC_HASHED: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !is_adapt && !is_spray) |=> sel_link == $past(s_hlink)); // R3

  AST_NEW_FLOW_HASHED: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_adapt && !ent_vld) |=> sel_link == $past(s_hlink)); // R4

  AST_SHORT_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_adapt && ent_vld && idle_gap <= s_gap) |=> sel_link == $past(ent_link)); // R5

  AST_MOVE_TO_FREE: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_adapt && ent_vld && idle_gap > s_gap && s_cong[ent_link] && !(&s_cong))
    |=> ((($past(s_cong) >> sel_link) & ONE_HOT0) == '0)); // R6

  AST_ALL_CONG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_adapt && ent_vld && (&s_cong)) |=> sel_link == $past(ent_link)); // R7

  AST_FREE_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_adapt && ent_vld && !s_cong[ent_link]) |=> sel_link == $past(ent_link)); // R8

  AST_SPRAY_FREE: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_spray && !(&s_cong))
    |=> ((($past(s_cong) >> sel_link) & ONE_HOT0) == '0)); // R10

  AST_SPRAY_ALL_CONG: assert property (@(posedge clk) disable iff (rst)
    (s_valid && is_spray && (&s_cong)) |=> (sel_link == $past(s_hlink) && $stable(rr_ptr))); // R11
endmodule

// File: rtl/path_sel_top.sv
module path_sel_top #(
  parameter int N_LINKS   = 4,
  parameter int HASH_W    = 16,
  parameter int TS_W      = 16,
  parameter int TBL_DEPTH = 64,
  localparam int LINK_W   = (N_LINKS > 1) ? $clog2(N_LINKS) : 1,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_mode,
  input  logic [TS_W-1:0]    cfg_gap,
  input  logic               pkt_valid,
  input  logic [HASH_W-1:0]  pkt_hash,
  input  logic [N_LINKS-1:0] link_cong,
  input  logic [TS_W-1:0]    now_ts,
  output logic               sel_valid,
  output logic [LINK_W-1:0]  sel_link
);
  logic [LINK_W-1:0]  fold, hlink;
  logic               s1_valid;
  logic [1:0]         s1_mode;
  logic [TS_W-1:0]    s1_gap, s1_ts;
  logic [N_LINKS-1:0] s1_cong;
  logic [LINK_W-1:0]  s1_hlink;
  logic               ent_vld;
  logic [LINK_W-1:0]  ent_link;
  logic [TS_W-1:0]    ent_ts;
  logic               wr_en;
  logic [LINK_W-1:0]  wr_link;
  logic [TS_W-1:0]    wr_ts;
  logic [IDX_W-1:0]   wr_idx;

  // fold the whole hash into a link index: hash bit i lands on link bit i mod LINK_W
  always_comb begin
    fold = '0;
    for (int b = 0; b < HASH_W; b++) fold[b % LINK_W] = fold[b % LINK_W] ^ pkt_hash[b];
  end
  assign hlink = LINK_W'(int'(fold) % N_LINKS);

  // stage 1: capture packet context alongside the synchronous table read
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= pkt_valid;
  end

  always_ff @(posedge clk) begin
    if (pkt_valid) begin
      s1_mode  <= cfg_mode;
      s1_gap   <= cfg_gap;
      s1_ts    <= now_ts;
      s1_cong  <= link_cong;
      s1_hlink <= hlink;
      wr_idx   <= pkt_hash[IDX_W-1:0];
    end
  end

  psel_flow_table #(
    .DEPTH  (TBL_DEPTH),
    .LINK_W (LINK_W),
    .TS_W   (TS_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (pkt_valid),
    .rd_addr (pkt_hash[IDX_W-1:0]),
    .rd_vld  (ent_vld),
    .rd_link (ent_link),
    .rd_ts   (ent_ts),
    .wr_en   (wr_en),
    .wr_addr (wr_idx),
    .wr_link (wr_link),
    .wr_ts   (wr_ts)
  );

  psel_decide #(
    .N_LINKS (N_LINKS),
    .TS_W    (TS_W)
  ) u_decide (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s1_valid),
    .s_mode    (s1_mode),
    .s_gap     (s1_gap),
    .s_ts      (s1_ts),
    .s_cong    (s1_cong),
    .s_hlink   (s1_hlink),
    .ent_vld   (ent_vld),
    .ent_link  (ent_link),
    .ent_ts    (ent_ts),
    .wr_en     (wr_en),
    .wr_link   (wr_link),
    .wr_ts     (wr_ts),
    .sel_valid (sel_valid),
    .sel_link  (sel_link)
  );

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> sel_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !sel_valid); // R2

  AST_LINK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (int'(sel_link) < N_LINKS)); // R2
endmodule

// File: tb/tb_path_sel_top.sv
module tb_path_sel_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_gap;
  logic        pkt_valid;
  logic [15:0] pkt_hash;
  logic [3:0]  link_cong;
  logic [15:0] now_ts;
  logic        sel_valid;
  logic [1:0]  sel_link;

  always #10 clk = ~clk;   // 50 MHz

  path_sel_top dut (
    .clk (clk), .rst (rst), .cfg_mode (cfg_mode), .cfg_gap (cfg_gap),
    .pkt_valid (pkt_valid), .pkt_hash (pkt_hash), .link_cong (link_cong),
    .now_ts (now_ts), .sel_valid (sel_valid), .sel_link (sel_link)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit          m_vld [64];
  logic [1:0]  m_link [64];
  logic [15:0] m_ts [64];
  logic [1:0]  m_rr;

  // two-deep expectation queue
  bit e1_v, e2_v;
  logic [1:0] e1_l, e2_l;
  string e1_t, e2_t;

  function automatic logic [1:0] fold(input logic [15:0] h);
    logic [1:0] f = 2'b00;
    for (int i = 0; i < 16; i++) f[i % 2] = f[i % 2] ^ h[i];
    return f;
  endfunction

  task automatic model(input logic [15:0] h, input logic [3:0] c, input logic [1:0] md,
                       input logic [15:0] t, output logic [1:0] l);
    int idx = int'(h[5:0]);
    logic [1:0] hl = fold(h);
    logic [15:0] gap;
    l = hl;
    if (md == 2'd1) begin
      if (m_vld[idx]) begin
        l = m_link[idx];
        gap = t - m_ts[idx];
        if (gap > cfg_gap && c[l] && c != 4'hF) begin
          for (int k = 3; k >= 0; k--) if (!c[k]) l = 2'(k);
        end
      end
    end else if (md == 2'd2) begin
      if (c != 4'hF) begin
        for (int k = 3; k >= 0; k--) begin
          int j = (int'(m_rr) + k) % 4;
          if (!c[j]) l = 2'(j);
        end
        m_rr = l + 2'd1;
      end
    end
    m_vld[idx] = 1'b1;
    m_link[idx] = l;
    m_ts[idx] = t;
  endtask

  task automatic check_now();
    n_chk++;
    if (sel_valid !== e2_v || (e2_v && sel_link !== e2_l)) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b link=%0d, expected valid=%0b link=%0d",
               e2_t, sel_valid, sel_link, e2_v, e2_l);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [15:0] h,
                      input logic [3:0] c, input logic [1:0] md, input logic [15:0] t);
    logic [1:0] l = 2'd0;
    @(negedge clk);
    check_now();
    e2_v = e1_v; e2_l = e1_l; e2_t = e1_t;
    if (v) model(h, c, md, t, l);
    e1_v = v; e1_l = l; e1_t = tag;
    pkt_valid = v; pkt_hash = h; link_cong = c; cfg_mode = md; now_ts = t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pkt_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    m_rr = 2'd0;
    e1_v = 0; e2_v = 0; e1_t = "R1"; e2_t = "R1";
  endtask

  initial begin
    logic [15:0] t_cur;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    rst = 1'b1; pkt_valid = 0; pkt_hash = 0; link_cong = 0; cfg_mode = 0;
    now_ts = 0; cfg_gap = 16'd20;
    do_reset();
    // R1: idle after reset
    step("R1", 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0);
    // R3: static ignores congestion of hashed link 3
    step("R3", 1, 16'h0003, 4'b1000, 2'd0, 16'd50);
    // R4: new flow A (idx 1, hashed link 1)
    step("R4", 1, 16'h0001, 4'b0000, 2'd1, 16'd100);
    // R5: short gap, own link congested, stays
    step("R5", 1, 16'h0001, 4'b0010, 2'd1, 16'd110);
    // R8: long gap, own link free, stays
    step("R8", 1, 16'h0001, 4'b0000, 2'd1, 16'd200);
    // R6: long gap, own link congested, move to link 2
    step("R6", 1, 16'h0001, 4'b0011, 2'd1, 16'd300);
    // R7: all congested, stays on 2
    step("R7", 1, 16'h0001, 4'b1111, 2'd1, 16'd400);
    // R12: flow B back to back, second sees the first's entry and migrates
    step("R12", 1, 16'h0005, 4'b0000, 2'd1, 16'd500);
    step("R12", 1, 16'h0005, 4'b0001, 2'd1, 16'd600);
    // R9: flow C across the timestamp wrap
    step("R9", 1, 16'h0002, 4'b0000, 2'd1, 16'hFFF0);
    step("R9", 1, 16'h0002, 4'b0100, 2'd1, 16'h0010);
    step("R9", 1, 16'h0002, 4'b0001, 2'd1, 16'h001A);
    // R2: bubbles
    step("R2", 0, 0, 0, 2'd0, 16'd0);
    step("R2", 0, 0, 0, 2'd0, 16'd0);
    // R10: spraying with skips
    step("R10", 1, 16'h0001, 4'b0000, 2'd2, 16'd700);
    step("R10", 1, 16'h0001, 4'b0010, 2'd2, 16'd701);
    step("R10", 1, 16'h0001, 4'b0000, 2'd2, 16'd702);
    step("R10", 1, 16'h0001, 4'b0001, 2'd2, 16'd703);
    // R11: all congested, hashed link, pointer held
    step("R11", 1, 16'h0003, 4'b1111, 2'd2, 16'd704);
    step("R11", 1, 16'h0009, 4'b0000, 2'd2, 16'd705);
    // random phase
    t_cur = 16'd1000;
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] md = 2'($urandom_range(0, 3));
      bit v = ($urandom_range(0, 7) != 0);
      logic [15:0] h = 16'($urandom_range(0, 7)) * 16'h1021;
      logic [3:0] c = 4'($urandom_range(0, 15));
      string tg = (md == 2'd1) ? "R6" : (md == 2'd2) ? "R10" : "R3";
      t_cur = t_cur + 16'($urandom_range(0, 40));
      step(tg, v, h, c, md, t_cur);
    end
    // R1: reset forgets flows and the spray pointer
    do_reset();
    step("R1", 1, 16'h0001, 4'b0010, 2'd1, 16'd9000);
    step("R1", 1, 16'h0001, 4'b0000, 2'd2, 16'd9001);
    step("R1", 0, 0, 0, 2'd0, 16'd0);
    step("R1", 0, 0, 0, 2'd0, 16'd0);
    step("R1", 0, 0, 0, 2'd0, 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule